// File: doc/BRIEF.md
# Table Pointer Read/Write Sequencer

This block runs the table-access instructions of a small processor core. It moves one byte between a byte-wide program memory and an 8-bit table latch, addressed by a 21-bit table pointer. A table read fetches a program-memory byte into the latch. A table write copies the latch into a 64-byte holding buffer outside the block, at the slot that the low pointer bits select. It never writes the main memory directly.

The core offers a 16-bit instruction word with a valid strobe. The block accepts it only when the word is one of the eight table opcodes and no operation is already running. Each accepted operation takes exactly two cycles, and `busy_o` is high for both of them.

In the first busy cycle the block issues the memory read or the buffer write, and the pointer is adjusted at the end of that cycle. In the second cycle, a read captures the returned byte into the latch. The pointer and the latch can be loaded directly through register write ports while the block is idle. The block updates no status flags.

Top module: `tblptr_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_ren_o` and `hold_we_o` are 0, and `ptr_o` and `latch_o` are all zeros.
- R2: The instruction word is accepted only when `instr_i[15:4]` is zero and `instr_i[3]` is 1, that is, for words 0x0008 to 0x000F. Bit 2 set means a write and bit 2 clear means a read. Any other word, or a word offered without `instr_valid_i`, starts nothing and leaves the pointer unchanged.
- R3: An accepted operation holds `busy_o` high for exactly the two cycles that follow the accepting clock edge, then drops it.
- R4: An instruction offered while `busy_o` is high is ignored: it adjusts nothing and does not lengthen or restart the operation in progress.
- R5: In a read, `mem_ren_o` is high only in the first busy cycle, with `mem_raddr_o` equal to the effective address. The memory returns the byte one cycle later, and the latch holds that byte from the cycle after the second busy cycle.
- R6: In a write, `hold_we_o` pulses for the first busy cycle only. During that pulse, `hold_waddr_o` holds the low 6 bits of the effective address and `hold_wdata_o` holds the latch value. The latch is not changed by a write.
- R7: Mode `instr_i[1:0]`=00 uses the pointer as the effective address and leaves the pointer unchanged.
- R8: Mode 01 uses the pointer as the effective address, then increments the pointer by one.
- R9: Mode 10 uses the pointer as the effective address, then decrements the pointer by one.
- R10: Mode 11 increments the pointer first, and uses the incremented value as the effective address.
- R11: Every pointer increment and decrement wraps modulo 2^21.
- R12: While the block is idle, `ptr_we_i` loads `ptr_wdata_i` into the pointer and `latch_we_i` loads `latch_wdata_i` into the latch, both at the next edge. While the block is busy, both loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word valid |
| instr_i | input | 16 | Instruction word |
| ptr_we_i | input | 1 | Direct pointer load strobe |
| ptr_wdata_i | input | 21 | Direct pointer load value |
| latch_we_i | input | 1 | Direct latch load strobe |
| latch_wdata_i | input | 8 | Direct latch load value |
| mem_ren_o | output | 1 | Program memory read enable |
| mem_raddr_o | output | 21 | Program memory read address |
| mem_rdata_i | input | 8 | Program memory read data, one cycle after the enable |
| hold_we_o | output | 1 | Holding buffer write enable |
| hold_waddr_o | output | 6 | Holding buffer slot |
| hold_wdata_o | output | 8 | Holding buffer write data |
| latch_o | output | 8 | Table latch value |
| ptr_o | output | 21 | Table pointer value |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions check on every cycle the properties that hold for every operation:
- the two-cycle busy window;
- mutual exclusion of the read and write strobes;
- the single-cycle write pulse, which carries the latch value;
- a pointer that moves by at most one step per busy cycle;
- a pointer that stays still while the block is idle and no load is requested.

Only the directed scenarios can show the values that each mode must produce:
- the effective address and the final pointer for each of the four adjust modes;
- the wrap at both ends of the 21-bit range;
- the byte captured by a read;
- that unrelated words, and instructions offered while busy, leave no trace.

// File: rtl/tblseq_pkg.sv
package tblseq_pkg;

  typedef enum logic [1:0] {
    ADJ_NONE     = 2'b00,
    ADJ_POST_INC = 2'b01,
    ADJ_POST_DEC = 2'b10,
    ADJ_PRE_INC  = 2'b11
  } adj_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACCESS = 2'b01,
    ST_FINISH = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic      is_tbl;
    logic      is_write;
    adj_mode_e mode;
  } tbl_op_t;

endpackage

// File: rtl/tblseq_decode.sv
module tblseq_decode
  import tblseq_pkg::*;
#(
  parameter int unsigned IW = 16
) (
  input  logic [IW-1:0] instr_i,
  output tbl_op_t       op_o
);

  localparam int unsigned HI_W = IW - 4;

  always_comb begin
    op_o.is_tbl   = (instr_i[IW-1:4] == {HI_W{1'b0}}) && instr_i[3];
    op_o.is_write = instr_i[2];
    op_o.mode     = adj_mode_e'(instr_i[1:0]);
  end

endmodule

// File: rtl/tblseq_ctrl.sv
module tblseq_ctrl
  import tblseq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  tbl_op_t   op_i,
  output adj_mode_e mode_o,
  output logic      busy_o,
  output logic      idle_o,
  output logic      rd_strobe_o,
  output logic      wr_strobe_o,
  output logic      step_o,
  output logic      latch_cap_o
);

  seq_state_e state_q, state_d;
  tbl_op_t    op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) op_q <= op_i;
    end
  end

  assign mode_o      = op_q.mode;
  assign idle_o      = (state_q == ST_IDLE);
  assign busy_o      = !idle_o;
  assign rd_strobe_o = (state_q == ST_ACCESS) && !op_q.is_write;
  assign wr_strobe_o = (state_q == ST_ACCESS) &&  op_q.is_write;
  assign step_o      = (state_q == ST_ACCESS);
  assign latch_cap_o = (state_q == ST_FINISH) && !op_q.is_write;

endmodule

// File: rtl/tblseq_ptr_unit.sv
module tblseq_ptr_unit
  import tblseq_pkg::*;
#(
  parameter int unsigned PTR_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             step_i,
  input  adj_mode_e        mode_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] eff_addr_o
);

  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec, ptr_d;

  // arithmetic wraps at the natural register width
  assign ptr_inc = ptr_q + ONE;
  assign ptr_dec = ptr_q - ONE;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (step_i) begin
      unique case (mode_i)
        ADJ_NONE:     ptr_d = ptr_q;
        ADJ_POST_INC: ptr_d = ptr_inc;
        ADJ_POST_DEC: ptr_d = ptr_dec;
        ADJ_PRE_INC:  ptr_d = ptr_inc;
        default:      ptr_d = ptr_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o      = ptr_q;
  assign eff_addr_o = (mode_i == ADJ_PRE_INC) ? ptr_inc : ptr_q;

endmodule

// File: rtl/tblptr_seq.sv
module tblptr_seq
  import tblseq_pkg::*;
#(
  parameter int unsigned IW     = 16,
  parameter int unsigned PTR_W  = 21,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUF_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [IW-1:0]     instr_i,
  input  logic              ptr_we_i,
  input  logic [PTR_W-1:0]  ptr_wdata_i,
  input  logic              latch_we_i,
  input  logic [DATA_W-1:0] latch_wdata_i,
  output logic              mem_ren_o,
  output logic [PTR_W-1:0]  mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              hold_we_o,
  output logic [BUF_AW-1:0] hold_waddr_o,
  output logic [DATA_W-1:0] hold_wdata_o,
  output logic [DATA_W-1:0] latch_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              busy_o
);

  tbl_op_t          dec_op;
  adj_mode_e        act_mode;
  logic             idle, start, step, latch_cap;
  logic             rd_strobe, wr_strobe;
  logic [PTR_W-1:0] eff_addr;
  logic [DATA_W-1:0] latch_q;

  tblseq_decode #(.IW(IW)) u_decode (
    .instr_i (instr_i),
    .op_o    (dec_op)
  );

  assign start = instr_valid_i && dec_op.is_tbl && idle;

  tblseq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .op_i        (dec_op),
    .mode_o      (act_mode),
    .busy_o      (busy_o),
    .idle_o      (idle),
    .rd_strobe_o (rd_strobe),
    .wr_strobe_o (wr_strobe),
    .step_o      (step),
    .latch_cap_o (latch_cap)
  );

  tblseq_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_we_i && idle),
    .load_val_i (ptr_wdata_i),
    .step_i     (step),
    .mode_i     (act_mode),
    .ptr_o      (ptr_o),
    .eff_addr_o (eff_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 latch_q <= '0;
    else if (latch_cap)          latch_q <= mem_rdata_i;
    else if (latch_we_i && idle) latch_q <= latch_wdata_i;
  end

  assign latch_o      = latch_q;
  assign mem_ren_o    = rd_strobe;
  assign mem_raddr_o  = eff_addr;
  assign hold_we_o    = wr_strobe;
  assign hold_waddr_o = eff_addr[BUF_AW-1:0];
  assign hold_wdata_o = latch_q;

endmodule

// File: rtl/tblseq_checker.sv
module tblseq_checker #(
  parameter int unsigned PTR_W  = 21,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ptr_we_i,
  input logic              mem_ren_o,
  input logic              hold_we_o,
  input logic [DATA_W-1:0] hold_wdata_o,
  input logic [DATA_W-1:0] latch_o,
  input logic [PTR_W-1:0]  ptr_o,
  input logic              busy_o
);

  logic             busy_q;
  logic [PTR_W-1:0] ptr_q, ptr_delta;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_o;
      ptr_q  <= ptr_o;
    end
  end

  assign ptr_delta = ptr_o - ptr_q;

  p_busy_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !busy_q) |=> busy_o);

  p_busy_ends_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && busy_q) |=> !busy_o);

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_ren_o && hold_we_o));

  p_ren_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ren_o |-> busy_o);

  p_hold_one_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we_o |=> !hold_we_o);

  p_hold_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we_o |-> (hold_wdata_o == latch_o));

  p_ptr_idle_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ptr_we_i) |=> $stable(ptr_o));

  p_ptr_step_bounded_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (ptr_delta == '0 || ptr_delta == {{(PTR_W-1){1'b0}}, 1'b1}
                || ptr_delta == '1));

endmodule

bind tblptr_seq tblseq_checker #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ptr_we_i     (ptr_we_i),
  .mem_ren_o    (mem_ren_o),
  .hold_we_o    (hold_we_o),
  .hold_wdata_o (hold_wdata_o),
  .latch_o      (latch_o),
  .ptr_o        (ptr_o),
  .busy_o       (busy_o)
);

// File: tb/tb_tblptr_seq.sv
module tb_tblptr_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        ptr_we_i = 1'b0;
  logic [20:0] ptr_wdata_i = '0;
  logic        latch_we_i = 1'b0;
  logic [7:0]  latch_wdata_i = '0;
  logic        mem_ren_o;
  logic [20:0] mem_raddr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        hold_we_o;
  logic [5:0]  hold_waddr_o;
  logic [7:0]  hold_wdata_o;
  logic [7:0]  latch_o;
  logic [20:0] ptr_o;
  logic        busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // sampled per operation
  logic        s1_busy, s1_ren, s1_we, s2_busy, s3_busy;
  logic [20:0] s1_raddr, s2_ptr;
  logic [5:0]  s1_waddr;
  logic [7:0]  s1_wdata, s3_latch;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tblptr_seq dut (.*);

  function automatic logic [7:0] mem_f(logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk_i) if (mem_ren_o) mem_rdata_i <= mem_f(mem_raddr_o);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_ptr(logic [20:0] v);
    @(negedge clk_i); ptr_we_i = 1'b1; ptr_wdata_i = v;
    @(negedge clk_i); ptr_we_i = 1'b0;
  endtask

  task automatic load_latch(logic [7:0] v);
    @(negedge clk_i); latch_we_i = 1'b1; latch_wdata_i = v;
    @(negedge clk_i); latch_we_i = 1'b0;
  endtask

  task automatic run_op(logic [15:0] w);
    @(negedge clk_i); instr_valid_i = 1'b1; instr_i = w;
    @(negedge clk_i); instr_valid_i = 1'b0; instr_i = '0;
    s1_busy = busy_o; s1_ren = mem_ren_o; s1_we = hold_we_o;
    s1_raddr = mem_raddr_o; s1_waddr = hold_waddr_o; s1_wdata = hold_wdata_o;
    @(negedge clk_i);
    s2_busy = busy_o; s2_ptr = ptr_o;
    @(negedge clk_i);
    s3_busy = busy_o; s3_latch = latch_o;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 ren", mem_ren_o, 0);
    chk("R1 we", hold_we_o, 0);
    chk("R1 ptr", ptr_o, 0);
    chk("R1 latch", latch_o, 0);
  endtask

  task automatic t_read_modes;
    load_ptr(21'h00100);
    load_latch(8'h00);
    run_op(16'h0008); // R7
    chk("R3 busy c1", s1_busy, 1); chk("R3 busy c2", s2_busy, 1); chk("R3 busy end", s3_busy, 0);
    chk("R5 ren", s1_ren, 1); chk("R5 no we", s1_we, 0);
    chk("R7 addr", s1_raddr, 21'h00100); chk("R7 ptr", s2_ptr, 21'h00100);
    chk("R5 latch", s3_latch, mem_f(21'h00100));
    run_op(16'h0009); // R8
    chk("R8 addr", s1_raddr, 21'h00100); chk("R8 ptr", s2_ptr, 21'h00101);
    chk("R8 latch", s3_latch, mem_f(21'h00100));
    run_op(16'h000A); // R9
    chk("R9 addr", s1_raddr, 21'h00101); chk("R9 ptr", s2_ptr, 21'h00100);
    chk("R9 latch", s3_latch, mem_f(21'h00101));
    run_op(16'h000B); // R10
    chk("R10 addr", s1_raddr, 21'h00101); chk("R10 ptr", s2_ptr, 21'h00101);
    chk("R10 latch", s3_latch, mem_f(21'h00101));
  endtask

  task automatic t_write_modes;
    load_ptr(21'h1203E);
    load_latch(8'hC3);
    run_op(16'h000D);
    chk("R6 we", s1_we, 1); chk("R6 no ren", s1_ren, 0);
    chk("R6 waddr", s1_waddr, 6'h3E); chk("R6 wdata", s1_wdata, 8'hC3);
    chk("R8 wr ptr", s2_ptr, 21'h1203F);
    chk("R6 latch kept", s3_latch, 8'hC3);
    chk("R3 wr busy", s3_busy, 0);
    run_op(16'h000F);
    chk("R10 wr waddr", s1_waddr, 6'h00); chk("R10 wr ptr", s2_ptr, 21'h12040);
    run_op(16'h000C);
    chk("R7 wr waddr", s1_waddr, 6'h00); chk("R7 wr ptr", s2_ptr, 21'h12040);
    run_op(16'h000E);
    chk("R9 wr waddr", s1_waddr, 6'h00); chk("R9 wr ptr", s2_ptr, 21'h1203F);
  endtask

  task automatic t_wrap;
    load_ptr(21'h1FFFFF);
    run_op(16'h0009);
    chk("R11 inc addr", s1_raddr, 21'h1FFFFF); chk("R11 inc wrap", s2_ptr, 21'h000000);
    run_op(16'h000A);
    chk("R11 dec addr", s1_raddr, 21'h000000); chk("R11 dec wrap", s2_ptr, 21'h1FFFFF);
    run_op(16'h000B);
    chk("R11 pre addr", s1_raddr, 21'h000000); chk("R11 pre wrap", s2_ptr, 21'h000000);
    chk("R11 latch", s3_latch, mem_f(21'h000000));
  endtask

  task automatic t_ignore;
    logic [15:0] bad[4] = '{16'h0007, 16'h0010, 16'h1008, 16'h8009};
    load_ptr(21'h00555);
    foreach (bad[i]) begin
      @(negedge clk_i); instr_valid_i = 1'b1; instr_i = bad[i];
      @(negedge clk_i); instr_valid_i = 1'b0;
      chk("R2 no busy", busy_o, 0);
      chk("R2 ptr kept", ptr_o, 21'h00555);
    end
    @(negedge clk_i); instr_valid_i = 1'b0; instr_i = 16'h0009;
    @(negedge clk_i);
    chk("R2 no valid", busy_o, 0);
    // R4 + R12: offers and loads during busy
    @(negedge clk_i); instr_valid_i = 1'b1; instr_i = 16'h0009;
    @(negedge clk_i); instr_i = 16'h000B; ptr_we_i = 1'b1; ptr_wdata_i = 21'h0AAAA;
    latch_we_i = 1'b1; latch_wdata_i = 8'h11;
    @(negedge clk_i); instr_i = 16'h000A;
    chk("R4 busy c2", busy_o, 1);
    instr_valid_i = 1'b0; ptr_we_i = 1'b0; latch_we_i = 1'b0;
    @(negedge clk_i);
    chk("R4 ended", busy_o, 0);
    chk("R4 ptr once", ptr_o, 21'h00556);
    chk("R12 busy load ignored", latch_o, mem_f(21'h00555));
    load_ptr(21'h0ABCD);
    chk("R12 ptr load", ptr_o, 21'h0ABCD);
    load_latch(8'h77);
    chk("R12 latch load", latch_o, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_read_modes();
    t_write_modes();
    t_wrap();
    t_ignore();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule